// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block runs one raw operation on an 8-bit NAND flash bus for each control word a host writes. A single word may chain up to four phases in a fixed order: a first command byte, address cycles, a second command byte, and a data phase of one to four bytes. The address cycles are either column bytes then row bytes, or one special zero cycle. The data phase either reads bytes into the data register or writes bytes taken from it. Setup, strobe width, hold and the wait before the flash can signal busy all come from a wait-count register. Each field of that register is a count of clock cycles.

The host loads the column, row, data, configuration and wait-count registers first. It then writes the control word with the start bit set and polls until the start bit reads back as zero. A hold bit keeps chip enable low after a word completes, so that several words form one flash transaction. The last word of a transaction leaves that bit clear. The ready/busy line of the flash is synchronised and shown in the status word. The host polls it after commands that make the flash busy.

Top module: `nand_seq`

## Requirements
- R1: After reset, status bit 31 reads 0, chip enable is high, both strobes are high, and CLE and ALE are low. An accepted control write (bit 31 set) makes bit 31 read 1 from the next cycle until the sequence ends.
- R2: Control bit 16 issues control bits [7:0] as a command cycle with CLE high. Bit 19 issues bits [15:8] as a command cycle after all address cycles.
- R3: Control bit 17 sends column-register bytes and bit 18 sends row-register bytes, least significant byte first, with ALE high. Column bytes go before row bytes. The column byte count is config bits [5:4] plus 1 and the row byte count is config bits [7:6] plus 1.
- R4: Control bit 24 sends exactly one address cycle of value 0x00 and suppresses the column and row cycles.
- R5: Control bit 20 reads (control bits [29:28] plus 1) bytes with RE# pulses. The first byte goes to data bits [7:0], the next bytes go to higher bytes, and the bytes not received read 0.
- R6: Control bit 21 writes (control bits [29:28] plus 1) bytes from the data register, bits [7:0] first, as WE# cycles with CLE and ALE low.
- R7: Chip enable is low during every strobe. When a sequence ends it stays low if control bit 30 was set, and otherwise it returns high.
- R8: Status bit 26 follows the ready/busy input after the synchroniser delay.
- R9: A start word with both bit 20 and bit 21 set is rejected. It causes no bus cycle and does not set busy, and it sets status bit 27. The next accepted start clears bit 27.
- R10: A control write made while busy is ignored, and the word in progress reads back unchanged.
- R11: Each WE# or RE# low pulse lasts wait field 0 cycles (minimum 1). WE# and RE# are never low together.
- R12: After the last command or address cycle of a word that has no data phase, busy falls exactly wait field 1 + wait field 4 + 1 cycles after WE# rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address: 0 control, 1 column, 2 row, 3 data, 4 config, 5 wait counts |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address (same map; 0 returns status) |
| reg_rdata | output | 32 | Read data |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus value driven by the block |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus value from the flash |
| nand_rb_n | input | 1 | Ready (1) / busy (0) from the flash |

## Verification
The assertions assume that the host changes the column, row, data, config and wait-count registers only while the engine is idle. They also assume that the flash drives the bus input only while RE# is low. The bench keeps to both: it polls the start bit until it clears before it loads any register. Its flash model presents each read byte at the falling edge of RE# and holds it until the next fall. The ready/busy input is toggled only between sequences, so the synchroniser delay is the only timing the status check depends on.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
   localparam int REG_DW = 32;

   localparam int A_CTRL = 0;
   localparam int A_COL  = 1;
   localparam int A_ROW  = 2;
   localparam int A_DATA = 3;
   localparam int A_CFG  = 4;
   localparam int A_TIM  = 5;

   localparam int B_CMD0 = 16;
   localparam int B_COL  = 17;
   localparam int B_ROW  = 18;
   localparam int B_CMD1 = 19;
   localparam int B_RD   = 20;
   localparam int B_WR   = 21;
   localparam int B_SPEC = 24;
   localparam int B_RDY  = 26;
   localparam int B_ERR  = 27;
   localparam int B_WID  = 28;
   localparam int B_HOLD = 30;
   localparam int B_GO   = 31;

   typedef enum logic [2:0] {
      K_NONE, K_CMD0, K_SPEC, K_COL, K_ROW, K_CMD1, K_RD, K_WR
   } kind_t;

   typedef enum logic [2:0] {
      S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_TWB, S_END
   } state_t;

   typedef struct packed {
      kind_t      k;
      logic [1:0] i;
   } item_t;

   function automatic logic is_cmd_grp(input kind_t k);
      return (k == K_CMD0) || (k == K_SPEC) || (k == K_COL) ||
             (k == K_ROW) || (k == K_CMD1);
   endfunction
endpackage

// File: rtl/nseq_sync.sv
module nseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {STAGES{RST_VAL}};
            else        sh <= {sh[STAGES-2:0], d};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/nseq_timer.sv
module nseq_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= (val == '0) ? '0 : val - W'(1);
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/nseq_regs.sv
module nseq_regs
   import nseq_pkg::*;
#(
   parameter int AW = 3,
   parameter int CW = 6,
   localparam int TW = 5 * CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [AW-1:0]     waddr,
   input  logic [REG_DW-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [REG_DW-1:0] rdata,
   input  logic              busy,
   input  logic              rb_ready,
   input  logic              rd_strobe,
   input  logic [1:0]        rd_idx,
   input  logic [7:0]        rd_byte,
   output logic              start,
   output logic              err,
   output logic [REG_DW-1:0] ctrl_q,
   output logic [REG_DW-1:0] col_q,
   output logic [REG_DW-1:0] row_q,
   output logic [REG_DW-1:0] data_q,
   output logic [7:0]        cfg_q,
   output logic [TW-1:0]     tim_q
);
   logic wr_ctrl, both_dir;
   logic [REG_DW-1:0] status;

   assign wr_ctrl  = wr && (waddr == AW'(A_CTRL)) && wdata[B_GO];
   assign both_dir = wdata[B_RD] && wdata[B_WR];
   assign start    = wr_ctrl && !busy && !both_dir;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         err    <= 1'b0;
      end else if (start) begin
         ctrl_q <= wdata;
         err    <= 1'b0;
      end else if (wr_ctrl && !busy) begin
         err    <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
         cfg_q <= '0;
         tim_q <= '0;
      end else if (wr) begin
         if (waddr == AW'(A_COL)) col_q <= wdata;
         if (waddr == AW'(A_ROW)) row_q <= wdata;
         if (waddr == AW'(A_CFG)) cfg_q <= wdata[7:0];
         if (waddr == AW'(A_TIM)) tim_q <= wdata[TW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (rd_strobe) begin
         if (rd_idx == 2'd0) data_q <= {24'h0, rd_byte};
         else                data_q[rd_idx*8 +: 8] <= rd_byte;
      end else if (wr && (waddr == AW'(A_DATA))) begin
         data_q <= wdata;
      end
   end

   always_comb begin
      status         = ctrl_q;
      status[B_GO]   = busy;
      status[B_ERR]  = err;
      status[B_RDY]  = rb_ready;
   end

   always_comb begin
      rdata = '0;
      if      (raddr == AW'(A_CTRL)) rdata = status;
      else if (raddr == AW'(A_COL))  rdata = col_q;
      else if (raddr == AW'(A_ROW))  rdata = row_q;
      else if (raddr == AW'(A_DATA)) rdata = data_q;
      else if (raddr == AW'(A_CFG))  rdata = {24'h0, cfg_q};
      else if (raddr == AW'(A_TIM))  rdata = {{(REG_DW-TW){1'b0}}, tim_q};
   end
endmodule

// File: rtl/nseq_fsm.sv
module nseq_fsm
   import nseq_pkg::*;
#(
   parameter int CW = 6,
   localparam int TW = 5 * CW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [REG_DW-1:0] start_word,
   input  logic [REG_DW-1:0] ctrl,
   input  logic [REG_DW-1:0] col,
   input  logic [REG_DW-1:0] row,
   input  logic [REG_DW-1:0] data,
   input  logic [7:0]        cfg,
   input  logic [TW-1:0]     tim,
   input  logic [7:0]        dq_in,
   output logic              busy,
   output logic              ce_n,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        dq_out,
   output logic              dq_oe,
   output logic              rd_strobe,
   output logic [1:0]        rd_idx,
   output logic [7:0]        rd_byte
);
   localparam int N_STAGE = 6;

   state_t  st_q, st_d;
   item_t   cur_q, cur_d, pend_q, pend_d, nxt, first0;
   logic    ce_q, ce_d;
   logic    tload, tdone;
   logic [CW-1:0] tval;
   logic [CW-1:0] w_pulse, w_hold, w_setup, w_dhold, w_twb;
   logic [2:0] stage_after;
   logic [1:0] lim;

   assign w_pulse = tim[0*CW +: CW];
   assign w_hold  = tim[1*CW +: CW];
   assign w_setup = tim[2*CW +: CW];
   assign w_dhold = tim[3*CW +: CW];
   assign w_twb   = tim[4*CW +: CW];

   function automatic item_t first_from(input logic [2:0] stg,
                                        input logic [REG_DW-1:0] c);
      item_t r;
      r.k = K_NONE;
      r.i = 2'd0;
      for (int s = 0; s < N_STAGE; s++) begin
         if (r.k == K_NONE && s >= int'(stg)) begin
            case (s)
               0: if (c[B_CMD0]) r.k = K_CMD0;
               1: if (c[B_SPEC]) r.k = K_SPEC;
               2: if (c[B_COL] && !c[B_SPEC]) r.k = K_COL;
               3: if (c[B_ROW] && !c[B_SPEC]) r.k = K_ROW;
               4: if (c[B_CMD1]) r.k = K_CMD1;
               default: begin
                  if (c[B_RD])      r.k = K_RD;
                  else if (c[B_WR]) r.k = K_WR;
               end
            endcase
         end
      end
      return r;
   endfunction

   assign first0 = first_from(3'd0, start_word);

   always_comb begin
      stage_after = 3'd6;
      lim         = 2'd0;
      case (cur_q.k)
         K_CMD0: stage_after = 3'd1;
         K_SPEC: stage_after = 3'd4;
         K_COL:  begin stage_after = 3'd3; lim = cfg[5:4]; end
         K_ROW:  begin stage_after = 3'd4; lim = cfg[7:6]; end
         K_CMD1: stage_after = 3'd5;
         K_RD, K_WR: begin stage_after = 3'd6; lim = ctrl[B_WID +: 2]; end
         default: stage_after = 3'd6;
      endcase
      if (cur_q.i != lim) begin
         nxt.k = cur_q.k;
         nxt.i = cur_q.i + 2'd1;
      end else begin
         nxt = first_from(stage_after, ctrl);
      end
   end

   always_comb begin
      st_d      = st_q;
      cur_d     = cur_q;
      pend_d    = pend_q;
      ce_d      = ce_q;
      tload     = 1'b0;
      tval      = '0;
      rd_strobe = 1'b0;
      case (st_q)
         S_IDLE: if (start) begin
            ce_d  = 1'b0;
            cur_d = first0;
            if (first0.k == K_NONE) begin
               st_d = S_END;
            end else begin
               st_d  = S_SETUP;
               tload = 1'b1;
               tval  = w_setup;
            end
         end
         S_SETUP: if (tdone) begin
            st_d  = S_PULSE;
            tload = 1'b1;
            tval  = w_pulse;
         end
         S_PULSE: if (tdone) begin
            st_d      = S_HOLD;
            tload     = 1'b1;
            tval      = (cur_q.k == K_WR) ? w_dhold : w_hold;
            rd_strobe = (cur_q.k == K_RD);
         end
         S_HOLD: if (tdone) begin
            if (is_cmd_grp(cur_q.k) && !is_cmd_grp(nxt.k)) begin
               st_d   = S_TWB;
               pend_d = nxt;
               tload  = 1'b1;
               tval   = w_twb;
            end else if (nxt.k == K_NONE) begin
               st_d = S_END;
            end else begin
               cur_d = nxt;
               st_d  = S_SETUP;
               tload = 1'b1;
               tval  = w_setup;
            end
         end
         S_TWB: if (tdone) begin
            if (pend_q.k == K_NONE) begin
               st_d = S_END;
            end else begin
               cur_d = pend_q;
               st_d  = S_SETUP;
               tload = 1'b1;
               tval  = w_setup;
            end
         end
         default: begin
            st_d = S_IDLE;
            ce_d = !ctrl[B_HOLD];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cur_q  <= '{k: K_NONE, i: 2'd0};
         pend_q <= '{k: K_NONE, i: 2'd0};
         ce_q   <= 1'b1;
      end else begin
         st_q   <= st_d;
         cur_q  <= cur_d;
         pend_q <= pend_d;
         ce_q   <= ce_d;
      end
   end

   nseq_timer #(.W(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tload),
      .val   (tval),
      .done  (tdone)
   );

   logic on_bus;
   assign on_bus = (st_q == S_SETUP) || (st_q == S_PULSE) || (st_q == S_HOLD);

   always_comb begin
      case (cur_q.k)
         K_CMD0:  dq_out = ctrl[7:0];
         K_CMD1:  dq_out = ctrl[15:8];
         K_COL:   dq_out = col[cur_q.i*8 +: 8];
         K_ROW:   dq_out = row[cur_q.i*8 +: 8];
         K_WR:    dq_out = data[cur_q.i*8 +: 8];
         default: dq_out = 8'h00;
      endcase
   end

   assign busy    = (st_q != S_IDLE);
   assign ce_n    = ce_q;
   assign cle     = on_bus && ((cur_q.k == K_CMD0) || (cur_q.k == K_CMD1));
   assign ale     = on_bus && ((cur_q.k == K_SPEC) || (cur_q.k == K_COL) ||
                               (cur_q.k == K_ROW));
   assign dq_oe   = on_bus && (cur_q.k != K_RD);
   assign we_n    = !((st_q == S_PULSE) && (cur_q.k != K_RD));
   assign re_n    = !((st_q == S_PULSE) && (cur_q.k == K_RD));
   assign rd_idx  = cur_q.i;
   assign rd_byte = dq_in;
endmodule

// File: rtl/nand_seq.sv
module nand_seq
   import nseq_pkg::*;
#(
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2,
   parameter int REG_AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [REG_AW-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic [7:0]        nand_dq_out,
   output logic              nand_dq_oe,
   input  logic [7:0]        nand_dq_in,
   input  logic              nand_rb_n
);
   localparam int TW = 5 * CNT_W;

   generate
      if (CNT_W < 2 || TW > 30) begin : g_bad_cnt
         $error("CNT_W must keep five counts inside 30 bits");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (REG_AW < 3) begin : g_bad_aw
         $error("REG_AW must address six registers");
      end
   endgenerate

   logic              seq_busy, seq_err, seq_start, rb_ready;
   logic              rd_strobe;
   logic [1:0]        rd_idx;
   logic [7:0]        rd_byte;
   logic [31:0]       ctrl_word, col_q, row_q, data_q;
   logic [7:0]        cfg_q;
   logic [TW-1:0]     tim_q;

   nseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (nand_rb_n),
      .q     (rb_ready)
   );

   nseq_regs #(.AW(REG_AW), .CW(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .waddr     (reg_waddr),
      .wdata     (reg_wdata),
      .raddr     (reg_raddr),
      .rdata     (reg_rdata),
      .busy      (seq_busy),
      .rb_ready  (rb_ready),
      .rd_strobe (rd_strobe),
      .rd_idx    (rd_idx),
      .rd_byte   (rd_byte),
      .start     (seq_start),
      .err       (seq_err),
      .ctrl_q    (ctrl_word),
      .col_q     (col_q),
      .row_q     (row_q),
      .data_q    (data_q),
      .cfg_q     (cfg_q),
      .tim_q     (tim_q)
   );

   nseq_fsm #(.CW(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (seq_start),
      .start_word (reg_wdata),
      .ctrl       (ctrl_word),
      .col        (col_q),
      .row        (row_q),
      .data       (data_q),
      .cfg        (cfg_q),
      .tim        (tim_q),
      .dq_in      (nand_dq_in),
      .busy       (seq_busy),
      .ce_n       (nand_ce_n),
      .cle        (nand_cle),
      .ale        (nand_ale),
      .we_n       (nand_we_n),
      .re_n       (nand_re_n),
      .dq_out     (nand_dq_out),
      .dq_oe      (nand_dq_oe),
      .rd_strobe  (rd_strobe),
      .rd_idx     (rd_idx),
      .rd_byte    (rd_byte)
   );
endmodule

// File: rtl/nseq_checker.sv
module nseq_checker #(
   parameter int AW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [AW-1:0] reg_waddr,
   input logic [31:0]   reg_wdata,
   input logic          busy,
   input logic          err,
   input logic [31:0]   ctrl_word,
   input logic          ce_n,
   input logic          cle,
   input logic          ale,
   input logic          we_n,
   input logic          re_n,
   input logic          dq_oe
);
   logic ctrl_go;
   assign ctrl_go = reg_wr && (reg_waddr == '0) && reg_wdata[31];

   assert_start_sets_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_go && !busy && !(reg_wdata[20] && reg_wdata[21])) |=> busy);

   assert_cle_ale_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale));

   assert_bus_off_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |-> !dq_oe);

   assert_ce_low_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !ce_n);

   assert_reject_both_dirs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_go && !busy && reg_wdata[20] && reg_wdata[21]) |=> (!busy && err));

   assert_ignore_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_go && busy) |=> $stable(ctrl_word));

   assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
endmodule

bind nand_seq nseq_checker #(.AW(REG_AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_waddr (reg_waddr),
   .reg_wdata (reg_wdata),
   .busy      (seq_busy),
   .err       (seq_err),
   .ctrl_word (ctrl_word),
   .ce_n      (nand_ce_n),
   .cle       (nand_cle),
   .ale       (nand_ale),
   .we_n      (nand_we_n),
   .re_n      (nand_re_n),
   .dq_oe     (nand_dq_oe)
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
   localparam int W0 = 2, W1 = 1, W2 = 1, W3 = 2, W4 = 3;
   localparam logic [1:0] K_C = 2'b10, K_A = 2'b01, K_D = 2'b00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_waddr = '0;
   logic [31:0] reg_wdata = '0;
   logic [2:0]  reg_raddr = '0;
   logic [31:0] reg_rdata;
   logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
   logic [7:0]  nand_dq_out;
   logic [7:0]  dq_in;
   logic        rb_n = 1'b1;

   int checks = 0, errors = 0, cyc = 0, last_rise = 0, idle_cyc = 0;
   bit finished = 0;
   logic [9:0]  exp_q[$];
   string       tag_q[$];
   logic [7:0]  rd_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc++;

   nand_seq u_nand_seq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
      .nand_dq_oe(nand_dq_oe), .nand_dq_in(dq_in), .nand_rb_n(rb_n)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic exp_bus(input logic [1:0] k, input logic [7:0] b, input string tag);
      exp_q.push_back({k, b});
      tag_q.push_back(tag);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_raddr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      bit ok = 0;
      for (int n = 0; n < 5000; n++) begin
         @(negedge clk);
         rd(3'd0, v);
         if (!v[31]) begin ok = 1; idle_cyc = cyc; break; end
      end
      if (!ok) chk("R1 busy never cleared", 32'd1, 32'd0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // monitor: scoreboard of WE# cycles and flash read model
   logic prev_we = 1'b1, prev_re = 1'b1;
   int we_low = 0, re_low = 0;
   logic [9:0] cap;
   always @(negedge clk) begin
      if (!rst_n) begin
         dq_in <= 8'h00;
      end else begin
         if (!nand_we_n) begin
            we_low++;
            cap = {nand_cle, nand_ale, nand_dq_out};
         end else if (!prev_we) begin
            chk("R11 WE# low width", we_low, W0);
            we_low = 0;
            last_rise = cyc;
            if (exp_q.size() == 0) begin
               chk("R2 unexpected bus cycle", {22'h0, cap}, 32'h3FF);
            end else begin
               logic [9:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, {22'h0, cap}, {22'h0, e});
            end
         end
         prev_we = nand_we_n;
         if (!nand_re_n) begin
            if (prev_re) dq_in <= (rd_q.size() != 0) ? rd_q.pop_front() : 8'hEE;
            re_low++;
         end else if (!prev_re) begin
            chk("R11 RE# low width", re_low, W0);
            re_low = 0;
         end
         prev_re = nand_re_n;
      end
   end

   initial begin
      #1_000_000;
      chk("watchdog expired", 32'd1, 32'd0);
      summary();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, v);
      chk("R1 reset busy", {31'h0, v[31]}, 32'd0);
      chk("R1 reset pins", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, 1'b0},
          {26'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      rst_n = 1'b1;
      @(negedge clk);

      wr(3'd5, (W4 << 24) | (W3 << 18) | (W2 << 12) | (W1 << 6) | W0);
      wr(3'd4, (2 << 6) | (1 << 4));  // 3 row bytes, 2 column bytes
      wr(3'd1, 32'h0000_0234);
      wr(3'd2, 32'h000A_0B0C);

      // page read setup: cmd 00, col, row, cmd 30, keep CE#
      exp_bus(K_C, 8'h00, "R2 first cmd");
      exp_bus(K_A, 8'h34, "R3 col byte0");
      exp_bus(K_A, 8'h02, "R3 col byte1");
      exp_bus(K_A, 8'h0C, "R3 row byte0");
      exp_bus(K_A, 8'h0B, "R3 row byte1");
      exp_bus(K_A, 8'h0A, "R3 row byte2");
      exp_bus(K_C, 8'h30, "R2 second cmd");
      wr(3'd0, 32'hC00F_3000);
      rd(3'd0, v);
      chk("R1 busy after start", {31'h0, v[31]}, 32'd1);
      wait_idle();
      chk("R12 tail after last WE#", idle_cyc - last_rise, W1 + W4 + 1);
      chk("R7 CE# held low", {31'h0, nand_ce_n}, 32'd0);

      // four-byte read, release CE#
      rd_q.push_back(8'hA1); rd_q.push_back(8'hB2);
      rd_q.push_back(8'hC3); rd_q.push_back(8'hD4);
      wr(3'd0, 32'hB010_0000);
      wait_idle();
      rd(3'd3, v);
      chk("R5 four-byte read packing", v, 32'hD4C3_B2A1);
      chk("R7 CE# released", {31'h0, nand_ce_n}, 32'd1);

      // single-byte read clears upper bytes
      wr(3'd3, 32'hFFFF_FFFF);
      rd_q.push_back(8'h5A);
      wr(3'd0, 32'h8010_0000);
      wait_idle();
      rd(3'd3, v);
      chk("R5 one-byte read", v, 32'h0000_005A);

      // program: cmd 80 + address, data, cmd 10
      exp_bus(K_C, 8'h80, "R2 program cmd");
      exp_bus(K_A, 8'h34, "R3 col byte0");
      exp_bus(K_A, 8'h02, "R3 col byte1");
      exp_bus(K_A, 8'h0C, "R3 row byte0");
      exp_bus(K_A, 8'h0B, "R3 row byte1");
      exp_bus(K_A, 8'h0A, "R3 row byte2");
      wr(3'd0, 32'hC007_0080);
      wait_idle();
      wr(3'd3, 32'h4433_2211);
      exp_bus(K_D, 8'h11, "R6 write byte0");
      exp_bus(K_D, 8'h22, "R6 write byte1");
      exp_bus(K_D, 8'h33, "R6 write byte2");
      exp_bus(K_D, 8'h44, "R6 write byte3");
      wr(3'd0, 32'hF020_0000);
      wait_idle();
      chk("R7 CE# held across words", {31'h0, nand_ce_n}, 32'd0);
      exp_bus(K_C, 8'h10, "R2 confirm cmd");
      wr(3'd0, 32'h8001_0010);
      wait_idle();
      chk("R7 CE# released after program", {31'h0, nand_ce_n}, 32'd1);

      // id read: special address overrides column and row
      exp_bus(K_C, 8'h90, "R2 id cmd");
      exp_bus(K_A, 8'h00, "R4 special address");
      wr(3'd0, 32'h8107_0090);
      wait_idle();

      // control write while busy is ignored
      exp_bus(K_C, 8'hAA, "R10 first word cmd");
      exp_bus(K_A, 8'h34, "R10 first word col0");
      exp_bus(K_A, 8'h02, "R10 first word col1");
      wr(3'd0, 32'h8003_00AA);
      wr(3'd0, 32'h8001_0077);
      wait_idle();
      rd(3'd0, v);
      chk("R10 word unchanged", {24'h0, v[7:0]}, 32'h0000_00AA);

      // both directions: rejected, error flag
      wr(3'd0, 32'h8031_0000);
      rd(3'd0, v);
      chk("R9 rejected not busy", {31'h0, v[31]}, 32'd0);
      chk("R9 error flag set", {31'h0, v[27]}, 32'd1);
      repeat (10) @(negedge clk);
      exp_bus(K_C, 8'hFF, "R9 next accepted cmd");
      wr(3'd0, 32'h8001_00FF);
      wait_idle();
      rd(3'd0, v);
      chk("R9 error flag cleared", {31'h0, v[27]}, 32'd0);

      // ready/busy mirror
      rb_n = 1'b0;
      repeat (4) @(negedge clk);
      rd(3'd0, v);
      chk("R8 ready low", {31'h0, v[26]}, 32'd0);
      rb_n = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd0, v);
      chk("R8 ready high", {31'h0, v[26]}, 32'd1);

      repeat (5) @(negedge clk);
      chk("R2 all expected cycles seen", exp_q.size(), 32'd0);
      summary();
   end
endmodule